// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host side of a read from a two-input, 10-bit successive-approximation converter that sits on a four-wire serial bus. A one-cycle request carries the input selection: single-ended or pseudo-differential, and which input or which polarity. When the block is idle it lowers chip-select and sends two bytes back to back, which is 16 serial clocks. It shifts the command out on falling serial-clock edges and samples the returned stream on rising edges.

The command is aligned with one leading zero. Because of that, the converter's null bit and its 10 result bits land at fixed positions in the two received bytes. The block keeps the two low bits of the first byte and all of the second byte. It presents the 10-bit code with a one-cycle valid pulse. The serial clock can idle low or idle high, and it runs at a rate set by a divider parameter.

Chip-select is then held high for a programmable gap before the next read. The busy output stays high until that gap has passed.

Top module: `adc_frame_reader`

## Requirements
- R1: During and after reset: `cs_n` is 1, `busy` is 0, `valid` is 0, `mosi` is 0, `result` is 0, and `sclk` equals `clk_idle_hi`.
- R2: A `req` sampled while `busy` is 0 lowers `cs_n` and raises `busy` in the next cycle. A `req` sampled while `busy` is 1 has no effect.
- R3: After `cs_n` falls, `sclk` holds its idle level for HALF_DIV cycles. It then produces 16 periods, each low for HALF_DIV cycles and then high for HALF_DIV cycles.
- R4: On `mosi` the block sends, in serial order, 0, 1, `sel_single`, `sel_odd`, ORDER_BIT (default 1), 0, 0, 0, followed by eight zeros. The first bit is driven from the fall of `cs_n`, each later bit changes only on a falling `sclk` edge, and `mosi` is 0 whenever `busy` is 0.
- R5: `miso` is sampled on each of the 16 rising `sclk` edges, MSB first. `result` is bits 1..0 of the first received byte above the whole second byte. `result` holds until the next read completes.
- R6: `valid` is high for exactly one cycle, in the cycle `cs_n` returns high, which is 33*HALF_DIV cycles after the accept.
- R7: The idle level of `sclk` is 0 when `clk_idle_hi` is 0 and 1 when it is 1. The level is latched at accept and kept until the gap ends. Both settings produce the same edge order inside the frame.
- R8: After a read, `cs_n` stays high and `busy` stays 1 for CS_GAP cycles. `cs_n` is never low for fewer than CS_GAP sampled high cycles between frames, even when `req` is held high.
- R9: The span from the 4th rising `sclk` edge to the falling edge after the 15th rising edge is 23*HALF_DIV cycles and does not exceed MAX_SPAN_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a read when idle |
| sel_single | input | 1 | 1 = single-ended, 0 = pseudo-differential |
| sel_odd | input | 1 | Input / polarity select |
| clk_idle_hi | input | 1 | Serial clock idle level |
| busy | output | 1 | Frame or gap in progress |
| valid | output | 1 | One-cycle result strobe |
| result | output | 10 | Extracted conversion code |
| cs_n | output | 1 | Chip-select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Command data to converter |
| miso | input | 1 | Data from converter |

## Verification
Every timed output is fixed relative to the accept edge, with H = HALF_DIV:
- `cs_n` falls one cycle after the accept.
- The first in-frame `sclk` edge comes H cycles later, and each half period lasts H cycles.
- `valid` and the rise of `cs_n` come 33H cycles after the accept.
- `busy` clears CS_GAP cycles after that.

A behavioural model in the bench counts cycles from the accept. It predicts `cs_n`, `busy`, `sclk`, `mosi`, `valid` and `result` for each cycle, and compares them on the falling clock edge, so every sample falls between register updates. A converter model attached to the pins returns a randomly drawn code for each input selection. It also records the command bits it received and times the conversion span in nanoseconds; both are checked on the valid cycle.

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int HALF_DIV     = 8,
  parameter int CS_GAP       = 16,
  parameter int MAX_SPAN_CYC = 400,
  parameter bit ORDER_BIT    = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       sel_single,
  input  logic       sel_odd,
  input  logic       clk_idle_hi,
  output logic       busy,
  output logic       valid,
  output logic [9:0] result,
  output logic       cs_n,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int FRAME_BITS = 16;
  localparam int HALVES     = 2 * FRAME_BITS;
  localparam int CNT_MAX    = (HALF_DIV > CS_GAP) ? HALF_DIV : CS_GAP;
  localparam int CW         = $clog2(CNT_MAX + 1);
  localparam int HW         = $clog2(HALVES);
  localparam int RES_W      = 10;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_XFER, S_GAP} st_t;

  st_t                   st;
  logic [CW-1:0]         cnt;
  logic [HW-1:0]         half;
  logic [FRAME_BITS-1:0] tx, rx;
  logic                  idle_lvl;

  wire [FRAME_BITS-1:0] cmd = {1'b0, 1'b1, sel_single, sel_odd, ORDER_BIT, 3'b000, 8'h00};
  wire half_end = (cnt == CW'(HALF_DIV - 1));

  assign busy = (st != S_IDLE);
  assign mosi = tx[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      half     <= '0;
      tx       <= '0;
      rx       <= '0;
      cs_n     <= 1'b1;
      sclk     <= clk_idle_hi;
      idle_lvl <= clk_idle_hi;
      result   <= '0;
      valid    <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req) begin
            st       <= S_SETUP;
            cnt      <= '0;
            cs_n     <= 1'b0;
            tx       <= cmd;
            idle_lvl <= clk_idle_hi;
          end else begin
            sclk <= clk_idle_hi;
          end
        end
        S_SETUP: begin
          if (half_end) begin
            cnt  <= '0;
            half <= '0;
            sclk <= 1'b0;
            st   <= S_XFER;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_XFER: begin
          if (half_end) begin
            cnt <= '0;
            if (half == HW'(HALVES - 1)) begin
              st     <= S_GAP;
              cs_n   <= 1'b1;
              sclk   <= idle_lvl;
              tx     <= '0;
              result <= rx[RES_W-1:0];
              valid  <= 1'b1;
            end else begin
              half <= half + 1'b1;
              if (!half[0]) begin
                sclk <= 1'b1;
                rx   <= {rx[FRAME_BITS-2:0], miso};
              end else begin
                sclk <= 1'b0;
                tx   <= {tx[FRAME_BITS-2:0], 1'b0};
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_GAP: begin
          if (cnt == CW'(CS_GAP - 1)) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
  parameter int CS_GAP       = 16,
  parameter int MAX_SPAN_CYC = 400
) (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic busy,
  input logic valid,
  input logic cs_n,
  input logic sclk,
  input logic mosi
);
  int   hi_run, rises, span;
  logic sclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run <= CS_GAP;
      rises  <= 0;
      span   <= 0;
      sclk_d <= sclk;
    end else begin
      sclk_d <= sclk;
      if (!cs_n) hi_run <= 0;
      else if (hi_run < CS_GAP) hi_run <= hi_run + 1;
      if (cs_n) begin
        rises <= 0;
        span  <= 0;
      end else begin
        if (sclk && !sclk_d) rises <= rises + 1;
        if (rises >= 4) span <= span + 1;
      end
    end
  end

  // R2
  start_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(req) && !$past(busy));

  // R2
  busy_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  // R3
  no_edge_at_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $stable(sclk));

  // R4
  mosi_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$stable(mosi)) |-> $fell(sclk));

  // R4
  mosi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mosi);

  // R6
  valid_at_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $rose(cs_n));

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R8
  gap_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> hi_run >= CS_GAP);

  // R9
  span_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && rises >= 4 && rises <= 15) |-> span <= MAX_SPAN_CYC);
endmodule

bind adc_frame_reader adc_frame_reader_chk #(
  .CS_GAP(CS_GAP), .MAX_SPAN_CYC(MAX_SPAN_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .valid(valid),
  .cs_n(cs_n), .sclk(sclk), .mosi(mosi)
);

// File: tb/sim_adc_frame_reader.sv
`timescale 1ns/1ps
module sim_adc_frame_reader;
  localparam int H    = 4;
  localparam int GAP  = 10;
  localparam int MAXS = 200;
  localparam int END  = 33 * H;

  logic clk = 0, rst_n = 0, req = 0, sel_single = 0, sel_odd = 0, clk_idle_hi = 0;
  logic busy, valid, cs_n, sclk, mosi;
  logic miso = 1'b1;
  logic [9:0] result;

  adc_frame_reader #(.HALF_DIV(H), .CS_GAP(GAP), .MAX_SPAN_CYC(MAXS)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .sel_single(sel_single), .sel_odd(sel_odd),
    .clk_idle_hi(clk_idle_hi), .busy(busy), .valid(valid), .result(result),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // converter model on the pins
  logic [9:0]  vals [4];
  logic [15:0] got_cmd = 0, last_cmd = 0;
  int          rcnt = 0, last_rc = 0, nb = 0, oidx = 0;
  bit          started = 0;
  logic [2:0]  cfg = 0;
  logic [9:0]  code = 0;
  time         t4 = 0, tend = 0;

  always @(posedge sclk) if (!cs_n) begin
    rcnt++;
    got_cmd = {got_cmd[14:0], mosi};
    if (rcnt == 4) t4 = $time;
    if (!started) begin
      if (mosi) started = 1;
    end else if (nb < 3) begin
      cfg = {cfg[1:0], mosi};
      nb++;
    end
  end

  always @(negedge sclk) if (!cs_n) begin
    if (rcnt == 15) tend = $time;
    if (started && nb == 3) begin
      if (oidx == 0) begin miso = 1'b0; code = vals[{cfg[2], cfg[1]}]; end
      else if (oidx <= 10) miso = code[10 - oidx];
      else miso = 1'b0;
      oidx++;
    end
  end

  always @(posedge cs_n) begin
    last_cmd = got_cmd; last_rc = rcnt;
    got_cmd = 0; rcnt = 0; started = 0; nb = 0; oidx = 0; miso = 1'b1;
  end

  // cycle reference model
  int k = -1;
  logic l_sgl = 0, l_odd = 0, l_cpol = 0, cpolp = 0;
  logic [9:0] l_val = 0, exp_res = 0;
  logic e_cs = 1, e_busy = 0, e_valid = 0, e_sclk = 0, e_mosi = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      k = -1; exp_res = 0;
    end else if (k < 0) begin
      if (req) begin
        k = 0; l_sgl = sel_single; l_odd = sel_odd; l_cpol = clk_idle_hi;
        l_val = vals[{sel_single, sel_odd}];
      end
    end else begin
      k = k + 1;
      if (k == END + GAP) k = -1;
    end
    cpolp   = clk_idle_hi;
    e_cs    = !(k >= 0 && k < END);
    e_busy  = (k >= 0);
    e_valid = (k == END);
    if (e_valid) exp_res = l_val;
    if (k < 0) e_sclk = cpolp;
    else if (k < H) e_sclk = l_cpol;
    else if (k < END) e_sclk = (((k - H) / H) % 2) == 1;
    else e_sclk = l_cpol;
    e_mosi = 1'b0;
    if (k >= 0 && k < END) begin
      int j;
      j = (k < H) ? 0 : (k - H) / (2 * H);
      case (j)
        1: e_mosi = 1'b1;
        2: e_mosi = l_sgl;
        3: e_mosi = l_odd;
        4: e_mosi = 1'b1;
        default: e_mosi = 1'b0;
      endcase
    end
  end

  int hi_cnt = 0;
  bit seen_low = 0;
  always @(negedge clk) if (rst_n && !finished) begin
    chk("R2 cs_n", cs_n, e_cs);
    chk("R8 busy", busy, e_busy);
    chk("R3/R7 sclk", sclk, e_sclk);
    chk("R4 mosi", mosi, e_mosi);
    chk("R6 valid", valid, e_valid);
    chk("R5 result", result, exp_res);
    if (valid) begin
      chk("R4 command bits", last_cmd, {1'b0, 1'b1, l_sgl, l_odd, 1'b1, 11'd0});
      chk("R3 clock count", last_rc, 16);
      chk("R9 span", 32'(tend - t4), 32'(23 * H * 20));
      chk("R9 span limit", 32'((tend - t4) <= MAXS * 20), 1);
    end
    if (cs_n) hi_cnt++;
    else begin
      if (seen_low && hi_cnt > 0) chk("R8 gap", 32'(hi_cnt >= GAP), 1);
      seen_low = 1; hi_cnt = 0;
    end
  end

  task automatic read_one(logic s, logic o);
    @(negedge clk); sel_single = s; sel_odd = o; req = 1;
    @(negedge clk); req = 0;
    repeat (5) @(negedge clk);
    req = 1; sel_single = ~s;   // R2: ignored while busy
    @(negedge clk); req = 0; sel_single = s;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    vals[0] = 10'h000; vals[1] = 10'h3FF; vals[2] = 10'h2AA; vals[3] = 10'h155;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 cs_n", cs_n, 1); chk("R1 busy", busy, 0); chk("R1 valid", valid, 0);
    chk("R1 mosi", mosi, 0); chk("R1 sclk", sclk, 0); chk("R1 result", result, 0);
    rst_n = 1;
    for (int p = 0; p < 2; p++) begin
      clk_idle_hi = p[0];   // R7
      repeat (4) @(negedge clk);
      for (int c = 0; c < 4; c++) read_one(c[1], c[0]);
      for (int r = 0; r < 4; r++) begin
        for (int v = 0; v < 4; v++) vals[v] = 10'($urandom);
        read_one(r[0], r[1]);
      end
    end
    // R8: request held high
    clk_idle_hi = 0;
    repeat (4) @(negedge clk);
    sel_single = 1; sel_odd = 1; req = 1;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      while (!valid) @(negedge clk);
    end
    req = 0;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1; total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule